// File: doc/BRIEF.md
# Base-Index-Displacement Address Generator

This unit computes byte addresses for a machine with sixteen 32-bit general registers. An instruction does not carry a full address. It carries a 12-bit displacement and two 4-bit register selectors. The first selector names a base register and the second names an optional index register. The unit reads the selected registers from its own register file and adds both values to the zero-extended displacement. It keeps the low 24 bits of the sum, which gives an address into a 16M-byte space.

A selector value of zero means "no register" and adds nothing. Register 0 is therefore never read for addressing. A request can also ask for the displacement alone. Software uses this to reach the locations where base values are loaded or saved before any base register holds a useful value. The register file has one write port that loads register contents.

Each request is a single cycle with `req_valid` high. The address appears in a register one cycle later. `addr_valid` pulses high for that one cycle, and `addr` holds its value until the next request.

Top module: `agu_top`

## Requirements
- R1: During and right after a synchronous active-low reset, `addr_valid` is 0 and `addr` is 0. All sixteen general registers read as zero until they are written.
- R2: A base selector or index selector equal to 0 contributes zero to the sum, even when register 0 holds a nonzero value.
- R3: For a request with `disp_only` low, `addr` equals the low 24 bits of base + index + zero-extended `disp`. Register n supplies the value for selector n, where n is 1 to 15.
- R4: Carries out of bit 23 are dropped. Bits 31:24 of the register values have no effect on the address, so sums past 0xFFFFFF wrap around to small addresses.
- R5: When `disp_only` is 1, the address equals the zero-extended `disp`, whatever the selectors and register contents are.
- R6: `addr_valid` is 1 exactly in the cycle after each cycle in which `req_valid` was 1. Requests on consecutive cycles give consecutive valid cycles, each with its own address.
- R7: In a cycle after `req_valid` was 0, `addr` keeps its previous value.
- R8: A register write takes effect at the clock edge that samples `wr_en`. A request in the same cycle as a write to the register it reads uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the general register file |
| wr_sel | input | 4 | Register number written |
| wr_data | input | 32 | Value written |
| req_valid | input | 1 | Address request strobe |
| base_sel | input | 4 | Base register selector, 0 = none |
| index_sel | input | 4 | Index register selector, 0 = none |
| disp | input | 12 | Unsigned displacement |
| disp_only | input | 1 | Use the displacement alone |
| addr_valid | output | 1 | One-cycle pulse marking a new address |
| addr | output | 24 | Registered byte address |

## Verification
The hardest case to reach is a carry out of bit 23. This needs register contents near the top of the 24-bit space, or with set upper bytes, together with a displacement that pushes the sum past 0xFFFFFF. The stimulus first loads registers such as 0x00FFFFF0 and 0xFFFFFFFF through the write port. It then issues requests whose sum wraps to exactly 0 or to a small value. A second hard case is a write and a read of the same register in one cycle. The bench drives both strobes on the same negative edge, so the ordering at the clock edge decides the result.

// File: rtl/agu_pkg.sv
// Package: shared widths for the address generator.
// Assumes: one set of defaults used by every module of the block.
package agu_pkg;
    localparam int DEF_REG_W  = 32;
    localparam int DEF_ADDR_W = 24;
    localparam int DEF_DISP_W = 12;
    localparam int DEF_NREGS  = 16;
    localparam int NUM_RD     = 2;

    // Index of each read port in the register file.
    typedef enum int {
        RD_BASE  = 0,
        RD_INDEX = 1
    } rd_port_e;
endpackage

// File: rtl/agu_gpr_file.sv
// Module: general register file with one write port and NRD read ports.
// Assumes: selector 0 on a read port returns zero and does not read the
// register (the "no register" code). The force_zero input also zeroes all
// read ports. Reads are combinational, and writes land at the clock edge.
module agu_gpr_file #(
    parameter int REG_W = agu_pkg::DEF_REG_W,
    parameter int NREGS = agu_pkg::DEF_NREGS,
    parameter int NRD   = agu_pkg::NUM_RD,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       force_zero,
    input  logic [NRD-1:0][SEL_W-1:0]  rd_sel,
    output logic [NRD-1:0][REG_W-1:0]  rd_val
);
    logic [REG_W-1:0] mem [NREGS];

    // Storage: clear on reset, otherwise accept one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_sel] <= wr_data;
        end
    end

    // One read port per generate iteration, each with zero-selector masking.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic sel_none;
        always_comb sel_none = (rd_sel[p] == '0) || force_zero;
        // Read port p: value of the selected register, or zero.
        always_comb rd_val[p] = sel_none ? '0 : mem[rd_sel[p]];
    end
endmodule

// File: rtl/agu_sum3.sv
// Module: three-input adder producing a wrapped byte address.
// Assumes: the displacement is unsigned. The sum is formed at register
// width and only its low ADDR_W bits are kept, so higher carries are lost.
module agu_sum3 #(
    parameter int REG_W  = agu_pkg::DEF_REG_W,
    parameter int ADDR_W = agu_pkg::DEF_ADDR_W,
    parameter int DISP_W = agu_pkg::DEF_DISP_W
) (
    input  logic [REG_W-1:0]  base_val,
    input  logic [REG_W-1:0]  index_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    localparam int PAD_W = REG_W - DISP_W;

    logic [REG_W-1:0] disp_ext;
    logic [REG_W-1:0] full_sum;

    // Zero-extend the displacement to register width.
    always_comb disp_ext = {{PAD_W{1'b0}}, disp};

    // Add all three terms at register width.
    always_comb full_sum = base_val + index_val + disp_ext;

    // Keep the low address bits and drop every carry above them.
    always_comb ea = full_sum[ADDR_W-1:0];
endmodule

// File: rtl/agu_out_stage.sv
// Module: output register for the address and its valid pulse.
// Assumes: a new address is captured only on a request, and the held
// address stays unchanged otherwise.
module agu_out_stage #(
    parameter int ADDR_W = agu_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    // Valid pulse: follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Address hold: load on a request, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_addr <= '0;
        else if (in_valid) out_addr <= in_addr;
    end
endmodule

// File: rtl/agu_top.sv
// Module: base + index + displacement effective-address generator.
// Assumes: sixteen general registers loaded through the write port, and
// one request per cycle with no back-pressure. The address is registered.
module agu_top #(
    parameter int REG_W  = agu_pkg::DEF_REG_W,
    parameter int ADDR_W = agu_pkg::DEF_ADDR_W,
    parameter int DISP_W = agu_pkg::DEF_DISP_W,
    parameter int NREGS  = agu_pkg::DEF_NREGS,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [SEL_W-1:0]  index_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic              disp_only,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr
);
    import agu_pkg::*;

    logic [NUM_RD-1:0][SEL_W-1:0] rd_sel;
    logic [NUM_RD-1:0][REG_W-1:0] rd_val;
    logic [ADDR_W-1:0]            ea_comb;

    // Route the two selectors to their read ports.
    always_comb begin
        rd_sel[RD_BASE]  = base_sel;
        rd_sel[RD_INDEX] = index_sel;
    end

    agu_gpr_file #(.REG_W(REG_W), .NREGS(NREGS), .NRD(NUM_RD)) u_gpr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .force_zero (disp_only),
        .rd_sel     (rd_sel),
        .rd_val     (rd_val)
    );

    agu_sum3 #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sum (
        .base_val  (rd_val[RD_BASE]),
        .index_val (rd_val[RD_INDEX]),
        .disp      (disp),
        .ea        (ea_comb)
    );

    agu_out_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_addr   (ea_comb),
        .out_valid (addr_valid),
        .out_addr  (addr)
    );
endmodule

// File: rtl/agu_checker.sv
// Module: timing and value checks on the address generator ports.
// Assumes: bound to every agu_top instance through the bind at the end.
module agu_checker #(
    parameter int ADDR_W = 24,
    parameter int DISP_W = 12,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SEL_W-1:0]  base_sel,
    input logic [SEL_W-1:0]  index_sel,
    input logic [DISP_W-1:0] disp,
    input logic              disp_only,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - DISP_W;

    // R6
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    // R6
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(addr));

    // R5
    disp_only_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && disp_only) |=> (addr == {{PAD_W{1'b0}}, $past(disp)}));

    // R2
    no_regs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_sel == '0 && index_sel == '0)
            |=> (addr == {{PAD_W{1'b0}}, $past(disp)}));
endmodule

bind agu_top agu_checker #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .base_sel   (base_sel),
    .index_sel  (index_sel),
    .disp       (disp),
    .disp_only  (disp_only),
    .addr_valid (addr_valid),
    .addr       (addr)
);

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  base_sel = '0;
    logic [3:0]  index_sel = '0;
    logic [11:0] disp = '0;
    logic        disp_only = 1'b0;
    logic        addr_valid;
    logic [23:0] addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] model [16];

    always #4 clk = ~clk;

    agu_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .base_sel(base_sel),
        .index_sel(index_sel), .disp(disp), .disp_only(disp_only),
        .addr_valid(addr_valid), .addr(addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_ea(input logic [3:0] b, input logic [3:0] x,
                                              input logic [11:0] d, input bit donly);
        logic [31:0] s;
        s = {20'd0, d};
        if (!donly && b != 0) s = s + model[b];
        if (!donly && x != 0) s = s + model[x];
        return s[23:0];
    endfunction

    task automatic write_reg(input logic [3:0] r, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = r; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[r] = v;
    endtask

    // One request, then a check of the pulse and the address in the next cycle.
    task automatic request(input string req, input logic [3:0] b, input logic [3:0] x,
                           input logic [11:0] d, input bit donly);
        logic [23:0] e;
        e = expect_ea(b, x, d, donly);
        @(negedge clk);
        req_valid = 1'b1; base_sel = b; index_sel = x; disp = d; disp_only = donly;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {31'd0, addr_valid}, 32'd1);
        check({req, " addr"}, {8'd0, addr}, {8'd0, e});
    endtask

    task automatic t_reset;
        check("R1 reset valid", {31'd0, addr_valid}, 32'd0);
        check("R1 reset addr", {8'd0, addr}, 32'd0);
        for (int i = 1; i < 16; i++) model[i] = '0;
        request("R1 regs zero after reset", 4'd7, 4'd9, 12'h123, 1'b0);
    endtask

    task automatic t_combos;
        write_reg(4'd3, 32'h0001_0000);
        write_reg(4'd5, 32'h0000_0240);
        request("R3 no base no index", 4'd0, 4'd0, 12'hABC, 1'b0);
        request("R3 base only", 4'd3, 4'd0, 12'h010, 1'b0);
        request("R3 index only", 4'd0, 4'd5, 12'h001, 1'b0);
        request("R3 base and index", 4'd3, 4'd5, 12'hFFF, 1'b0);
    endtask

    task automatic t_reg0;
        write_reg(4'd0, 32'h0055_5555);
        model[0] = '0; // selector 0 must contribute zero
        request("R2 base field zero", 4'd0, 4'd3, 12'h004, 1'b0);
        request("R2 both fields zero", 4'd0, 4'd0, 12'h004, 1'b0);
    endtask

    task automatic t_wrap;
        write_reg(4'd8, 32'h00FF_FFF0);
        write_reg(4'd9, 32'hFFFF_FFFF);
        write_reg(4'd10, 32'h0000_0001);
        write_reg(4'd11, 32'hAB00_0100);
        request("R4 disp wraps base", 4'd8, 4'd0, 12'h020, 1'b0);
        request("R4 wraps to zero", 4'd9, 4'd10, 12'h000, 1'b0);
        check("R4 wrap value", {8'd0, addr}, 32'd0);
        request("R4 upper byte ignored", 4'd11, 4'd0, 12'h005, 1'b0);
        check("R4 upper byte value", {8'd0, addr}, 32'h0000_0105);
    endtask

    task automatic t_disp_only;
        request("R5 disp only", 4'd9, 4'd8, 12'h7E4, 1'b1);
        check("R5 disp only value", {8'd0, addr}, 32'h0000_07E4);
    endtask

    task automatic t_hold_b2b;
        logic [23:0] e1, e2;
        request("R7 setup", 4'd3, 4'd0, 12'h222, 1'b0);
        e1 = addr;
        @(negedge clk);
        base_sel = 4'd5; disp = 12'h999;
        @(negedge clk);
        check("R6 no pulse without request", {31'd0, addr_valid}, 32'd0);
        check("R7 addr held", {8'd0, addr}, {8'd0, e1});
        e1 = expect_ea(4'd3, 4'd5, 12'h011, 1'b0);
        e2 = expect_ea(4'd8, 4'd0, 12'h003, 1'b0);
        req_valid = 1'b1; base_sel = 4'd3; index_sel = 4'd5; disp = 12'h011; disp_only = 1'b0;
        @(negedge clk);
        check("R6 b2b first valid", {31'd0, addr_valid}, 32'd1);
        check("R6 b2b first addr", {8'd0, addr}, {8'd0, e1});
        base_sel = 4'd8; index_sel = 4'd0; disp = 12'h003;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 b2b second valid", {31'd0, addr_valid}, 32'd1);
        check("R6 b2b second addr", {8'd0, addr}, {8'd0, e2});
        @(negedge clk);
        check("R6 single pulse", {31'd0, addr_valid}, 32'd0);
    endtask

    task automatic t_same_cycle;
        logic [23:0] e_old;
        e_old = expect_ea(4'd5, 4'd0, 12'h000, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd5; wr_data = 32'h0012_3400;
        req_valid = 1'b1; base_sel = 4'd5; index_sel = 4'd0; disp = 12'h000; disp_only = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        model[5] = 32'h0012_3400;
        check("R8 same cycle uses old", {8'd0, addr}, {8'd0, e_old});
        request("R8 next request uses new", 4'd5, 4'd0, 12'h056, 1'b0);
    endtask

    task automatic t_all_regs;
        for (int i = 1; i < 16; i++) write_reg(i[3:0], 32'h0000_1000 * i + i);
        for (int i = 1; i < 16; i++) request("R3 each register", i[3:0], 4'd0, 12'h000, 1'b0);
        request("R3 index from r15", 4'd1, 4'd15, 12'h0F0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset;
        t_combos;
        t_reg0;
        t_wrap;
        t_disp_only;
        t_hold_b2b;
        t_same_cycle;
        t_all_regs;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Checks outputs while reset is still held.
    task automatic t_reset_pre;
        check("R1 valid in reset", {31'd0, addr_valid}, 32'd0);
        check("R1 addr in reset", {8'd0, addr}, 32'd0);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule